// File: doc/BRIEF.md
# Display RAM Address Counter

This block keeps the 7-bit address used for every access to the display character store and the user glyph store of a character LCD controller. A host command loads it, either as a full display address or as a glyph-store address. Each data read or write then moves it one place up or down, and the entry direction chooses which way.

When it points into the display store, the counter follows the line layout. In one-line, two-line and four-line organisations, each line starts at 0x00, 0x20, 0x40 or 0x60 as the organisation requires. Stepping past the last cell of a line lands on the first cell of the next line, and from the last line it goes back to the first line. Stepping down takes the same jumps in reverse. When it points into the glyph store, it counts plainly modulo 128. A second output tells the RAM side which store is the current target. The status read path can return all seven bits as they stand.

Top module: `dram_addr_ctr`

## Requirements
- R1: While reset is asserted, and after it is released, `addr` is 0x00 and `sel_char` is 0 (display store).
- R2: A `ld_disp` pulse loads all seven bits of `ld_val` into `addr` and clears `sel_char`.
- R3: A `ld_char` pulse without `ld_disp` loads `ld_val[5:0]` into `addr[5:0]`, keeps `addr[6]` unchanged and sets `sel_char`.
- R4: Priority is `ld_disp` first, then `ld_char`, then `step`. A step given in the same cycle as a load has no effect.
- R5: With `sel_char`=1, a step moves `addr` by one modulo 128, up when `step_up`=1 and down otherwise. This includes the carry from 0x3F to 0x40 and the wrap from 0x7F to 0x00.
- R6: Line mode 2'b00 (one line, 80 cells): stepping up goes from 0x4F to 0x00, and stepping down goes from 0x00 to 0x4F.
- R7: Line mode 2'b01 (two lines, 40 cells at 0x00 and 0x40): stepping up goes from 0x27 to 0x40 and from 0x67 to 0x00. Stepping down goes from 0x40 to 0x27 and from 0x00 to 0x67.
- R8: Line mode 2'b10 (four lines, 20 cells at 0x00, 0x20, 0x40 and 0x60): stepping up goes from 0x13 to 0x20, 0x33 to 0x40, 0x53 to 0x60 and 0x73 to 0x00. Stepping down goes from 0x20 to 0x13, 0x40 to 0x33, 0x60 to 0x53 and 0x00 to 0x73.
- R9: In display mode, a step that is not at a line boundary moves by one modulo 128. This includes addresses in the gaps between lines. Line mode 2'b11 behaves as one-line mode.
- R10: With no load and no step, `addr` and `sel_char` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_disp | input | 1 | Load a display address from `ld_val` |
| ld_char | input | 1 | Load a glyph-store address from `ld_val[5:0]` |
| ld_val | input | 7 | Address value carried by the load command |
| step | input | 1 | One data read or write has taken place |
| step_up | input | 1 | Entry direction: 1 up, 0 down |
| line_mode | input | 2 | 00 one line, 01 two lines, 10 four lines, 11 as 00 |
| addr | output | 7 | Current address |
| sel_char | output | 1 | 1 when the glyph store is the target |

## Verification
The assertions assume that the control inputs are 0 while reset is low. They also assume that `line_mode` does not change in the same cycle as a step that depends on it. The bench meets both: it drives every input to 0 during reset, and it changes `line_mode` only on the falling edge, together with the command it goes with. The jump checks assume the address starts inside a line. The bench therefore loads a line-end or line-start address before each step that is meant to cross a boundary. Gap addresses are only stepped in the vectors tagged for linear counting.

// File: rtl/dac_pkg.sv
package dac_pkg;

  localparam int ADDR_W = 7;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    addr_t nxt;
    logic  jump;
  } step_res_t;

  // Plain modulo-2**ADDR_W step used for the glyph store
  function automatic addr_t flat_step(addr_t a, logic up);
    return up ? addr_t'(a + 1'b1) : addr_t'(a - 1'b1);
  endfunction

  // Line-aware step: lines of `len` cells placed every `stride` addresses
  function automatic step_res_t line_step(addr_t a, logic up, int nlines,
                                          int len, int stride);
    step_res_t r;
    int unsigned idx;
    int unsigned off;
    idx    = int'(a) / stride;
    off    = int'(a) % stride;
    r.jump = 1'b0;
    r.nxt  = flat_step(a, up);
    if (up && off == len - 1) begin
      r.nxt  = addr_t'(((idx + 1) % nlines) * stride);
      r.jump = 1'b1;
    end else if (!up && off == 0) begin
      r.nxt  = addr_t'(((idx + nlines - 1) % nlines) * stride + len - 1);
      r.jump = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/dac_line_step.sv
module dac_line_step
  import dac_pkg::*;
#(
  parameter int NLINES   = 1,
  parameter int LINE_LEN = 80
) (
  input  addr_t addr_i,
  input  logic  up_i,
  output addr_t nxt_o,
  output logic  jump_o
);
  localparam int STRIDE = (1 << ADDR_W) / NLINES;

  step_res_t res;

  always_comb res = line_step(addr_i, up_i, NLINES, LINE_LEN, STRIDE);

  assign nxt_o  = res.nxt;
  assign jump_o = res.jump;
endmodule

// File: rtl/dac_addr_reg.sv
module dac_addr_reg
  import dac_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld_disp,
  input  logic  ld_char,
  input  logic  step,
  input  addr_t ld_val,
  input  addr_t step_nxt,
  output addr_t addr_q,
  output logic  sel_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      sel_q  <= 1'b0;
    end else if (ld_disp) begin
      addr_q <= ld_val;
      sel_q  <= 1'b0;
    end else if (ld_char) begin
      addr_q <= {addr_q[ADDR_W-1], ld_val[ADDR_W-2:0]};
      sel_q  <= 1'b1;
    end else if (step) begin
      addr_q <= step_nxt;
    end
  end

  // R4: a load always beats a step in the same cycle
  a_r4_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_disp && step) |=> (addr_q == $past(ld_val)));
endmodule

// File: rtl/dram_addr_ctr.sv
module dram_addr_ctr
  import dac_pkg::*;
#(
  parameter int LEN_1L = 80,
  parameter int LEN_2L = 40,
  parameter int LEN_4L = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_disp,
  input  logic       ld_char,
  input  logic [6:0] ld_val,
  input  logic       step,
  input  logic       step_up,
  input  logic [1:0] line_mode,
  output logic [6:0] addr,
  output logic       sel_char
);
  localparam int NMODES = 3;

  addr_t cand_nxt  [NMODES];
  logic  cand_jump [NMODES];
  addr_t disp_nxt, char_nxt, step_nxt;
  logic  line_jump;
  logic  disp_step;
  int unsigned msel;

  genvar g;
  generate
    for (g = 0; g < NMODES; g++) begin : g_mode
      localparam int LEN = (g == 0) ? LEN_1L : (g == 1) ? LEN_2L : LEN_4L;
      dac_line_step #(.NLINES(1 << g), .LINE_LEN(LEN)) u_ls (
        .addr_i (addr),
        .up_i   (step_up),
        .nxt_o  (cand_nxt[g]),
        .jump_o (cand_jump[g])
      );
    end
  endgenerate

  always_comb begin
    unique case (line_mode)
      2'b01:   msel = 1;
      2'b10:   msel = 2;
      default: msel = 0;
    endcase
  end

  assign disp_nxt  = cand_nxt[msel];
  assign line_jump = cand_jump[msel] && !sel_char;
  assign char_nxt  = flat_step(addr, step_up);
  assign step_nxt  = sel_char ? char_nxt : disp_nxt;
  assign disp_step = step && !ld_disp && !ld_char && !sel_char;

  dac_addr_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_disp  (ld_disp),
    .ld_char  (ld_char),
    .step     (step),
    .ld_val   (ld_val),
    .step_nxt (step_nxt),
    .addr_q   (addr),
    .sel_q    (sel_char)
  );

  // R2: full display-address load
  a_r2_disp_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_disp |=> (addr == $past(ld_val) && !sel_char));

  // R3: glyph-address load keeps the top bit
  a_r3_char_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_char && !ld_disp) |=> (addr[5:0] == $past(ld_val[5:0]) &&
                               addr[6] == $past(addr[6]) && sel_char));

  // R5: glyph-store steps count by one in either direction
  a_r5_char_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step && step_up && sel_char && !ld_disp && !ld_char)
      |=> (addr == addr_t'($past(addr) + 1'b1)));
  a_r5_char_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !step_up && sel_char && !ld_disp && !ld_char)
      |=> (addr == addr_t'($past(addr) - 1'b1)));

  // R6: one-line end wraps to the start
  a_r6_one_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_step && step_up && line_mode == 2'b00 && addr == 7'h4F)
      |=> (addr == 7'h00));

  // R7: two-line jump out of line 1 lands on line 2
  a_r7_two_line_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_step && step_up && line_mode == 2'b01 && addr == 7'h27)
      |=> (addr == 7'h40));

  // R8: every four-line jump up lands on a line start
  a_r8_four_line_start: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_step && step_up && line_mode == 2'b10 && line_jump)
      |=> (addr[4:0] == 5'd0));

  // R9: a display step off a boundary moves by exactly one
  a_r9_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_step && step_up && !line_jump)
      |=> (addr == addr_t'($past(addr) + 1'b1)));

  // R10: idle cycles hold state
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_disp && !ld_char && !step) |=> ($stable(addr) && $stable(sel_char)));
endmodule

// File: tb/sim_dram_addr_ctr.sv
module sim_dram_addr_ctr;
  localparam int CLK_P = 10;
  localparam int NV    = 40;

  // [28:26] op  [25:19] value  [18] up  [17:16] mode  [15:9] expected addr
  // [8] expected sel  [7:0] requirement number
  // op: 0 idle, 1 ld_disp, 2 ld_char, 3 step, 4 all three, 5 ld_char+step
  typedef logic [28:0] vec_t;
  localparam vec_t TBL [NV] = '{
    {3'd1, 7'h4F, 1'b0, 2'd0, 7'h4F, 1'b0, 8'd2},  // R2
    {3'd3, 7'h00, 1'b1, 2'd0, 7'h00, 1'b0, 8'd6},  // R6 up wrap
    {3'd3, 7'h00, 1'b0, 2'd0, 7'h4F, 1'b0, 8'd6},  // R6 down wrap
    {3'd1, 7'h27, 1'b0, 2'd1, 7'h27, 1'b0, 8'd2},  // R2
    {3'd3, 7'h00, 1'b1, 2'd1, 7'h40, 1'b0, 8'd7},  // R7
    {3'd1, 7'h67, 1'b0, 2'd1, 7'h67, 1'b0, 8'd2},  // R2
    {3'd3, 7'h00, 1'b1, 2'd1, 7'h00, 1'b0, 8'd7},  // R7
    {3'd3, 7'h00, 1'b0, 2'd1, 7'h67, 1'b0, 8'd7},  // R7
    {3'd1, 7'h40, 1'b0, 2'd1, 7'h40, 1'b0, 8'd2},  // R2
    {3'd3, 7'h00, 1'b0, 2'd1, 7'h27, 1'b0, 8'd7},  // R7
    {3'd1, 7'h13, 1'b0, 2'd2, 7'h13, 1'b0, 8'd2},  // R2
    {3'd3, 7'h00, 1'b1, 2'd2, 7'h20, 1'b0, 8'd8},  // R8
    {3'd1, 7'h33, 1'b0, 2'd2, 7'h33, 1'b0, 8'd2},  // R2
    {3'd3, 7'h00, 1'b1, 2'd2, 7'h40, 1'b0, 8'd8},  // R8
    {3'd1, 7'h53, 1'b0, 2'd2, 7'h53, 1'b0, 8'd2},  // R2
    {3'd3, 7'h00, 1'b1, 2'd2, 7'h60, 1'b0, 8'd8},  // R8
    {3'd1, 7'h73, 1'b0, 2'd2, 7'h73, 1'b0, 8'd2},  // R2
    {3'd3, 7'h00, 1'b1, 2'd2, 7'h00, 1'b0, 8'd8},  // R8
    {3'd3, 7'h00, 1'b0, 2'd2, 7'h73, 1'b0, 8'd8},  // R8
    {3'd1, 7'h60, 1'b0, 2'd2, 7'h60, 1'b0, 8'd2},  // R2
    {3'd3, 7'h00, 1'b0, 2'd2, 7'h53, 1'b0, 8'd8},  // R8
    {3'd1, 7'h20, 1'b0, 2'd2, 7'h20, 1'b0, 8'd2},  // R2
    {3'd3, 7'h00, 1'b0, 2'd2, 7'h13, 1'b0, 8'd8},  // R8
    {3'd1, 7'h45, 1'b0, 2'd1, 7'h45, 1'b0, 8'd2},  // R2
    {3'd2, 7'h12, 1'b0, 2'd1, 7'h52, 1'b1, 8'd3},  // R3 keeps bit 6
    {3'd3, 7'h00, 1'b1, 2'd1, 7'h53, 1'b1, 8'd5},  // R5
    {3'd1, 7'h00, 1'b0, 2'd1, 7'h00, 1'b0, 8'd2},  // R2
    {3'd2, 7'h3F, 1'b0, 2'd1, 7'h3F, 1'b1, 8'd3},  // R3
    {3'd3, 7'h00, 1'b1, 2'd1, 7'h40, 1'b1, 8'd5},  // R5 carry into bit 6
    {3'd2, 7'h3F, 1'b0, 2'd1, 7'h7F, 1'b1, 8'd3},  // R3
    {3'd3, 7'h00, 1'b1, 2'd1, 7'h00, 1'b1, 8'd5},  // R5 wrap up
    {3'd3, 7'h00, 1'b0, 2'd1, 7'h7F, 1'b1, 8'd5},  // R5 wrap down
    {3'd0, 7'h11, 1'b1, 2'd2, 7'h7F, 1'b1, 8'd10}, // R10 idle holds
    {3'd1, 7'h2A, 1'b0, 2'd1, 7'h2A, 1'b0, 8'd2},  // R2
    {3'd3, 7'h00, 1'b1, 2'd1, 7'h2B, 1'b0, 8'd9},  // R9 gap counts linearly
    {3'd1, 7'h7F, 1'b0, 2'd0, 7'h7F, 1'b0, 8'd2},  // R2
    {3'd3, 7'h00, 1'b1, 2'd0, 7'h00, 1'b0, 8'd9},  // R9 linear wrap
    {3'd1, 7'h4F, 1'b0, 2'd3, 7'h4F, 1'b0, 8'd2},  // R2
    {3'd3, 7'h00, 1'b1, 2'd3, 7'h00, 1'b0, 8'd9},  // R9 mode 11 as one line
    {3'd4, 7'h15, 1'b1, 2'd1, 7'h15, 1'b0, 8'd4}   // R4 ld_disp wins
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ld_disp, ld_char, step, step_up;
  logic [6:0] ld_val;
  logic [1:0] line_mode;
  logic [6:0] addr;
  logic       sel_char;
  int         checks = 0;
  int         fails  = 0;
  logic       done   = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  dram_addr_ctr u0 (
    .clk(clk), .rst_n(rst_n), .ld_disp(ld_disp), .ld_char(ld_char),
    .ld_val(ld_val), .step(step), .step_up(step_up), .line_mode(line_mode),
    .addr(addr), .sel_char(sel_char)
  );

  task automatic check(input int req, input logic [6:0] ea, input logic es);
    checks++;
    if (addr !== ea || sel_char !== es) begin
      fails++;
      $display("FAIL R%0d addr=%02h sel=%0b expected addr=%02h sel=%0b",
               req, addr, sel_char, ea, es);
    end
  endtask

  task automatic idle_inputs();
    ld_disp = 0; ld_char = 0; step = 0; step_up = 0; ld_val = '0;
  endtask

  task automatic apply(input logic [2:0] op, input logic [6:0] v,
                       input logic up, input logic [1:0] m);
    ld_val = v; step_up = up; line_mode = m;
    ld_disp = (op == 3'd1 || op == 3'd4);
    ld_char = (op == 3'd2 || op == 3'd4 || op == 3'd5);
    step    = (op == 3'd3 || op == 3'd4 || op == 3'd5);
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    rst_n = 0; line_mode = 2'd0;
    idle_inputs();
    repeat (3) @(negedge clk);
    check(1, 7'h00, 1'b0);  // R1 during reset
    rst_n = 1;
    @(negedge clk);
    check(1, 7'h00, 1'b0);  // R1 after release

    for (int i = 0; i < NV; i++) begin
      apply(TBL[i][28:26], TBL[i][25:19], TBL[i][18], TBL[i][17:16]);
      check(int'(TBL[i][7:0]), TBL[i][15:9], TBL[i][8]);
    end

    // R4: ld_char with a step: load wins, bit 6 of 0x15 (0) kept
    apply(3'd5, 7'h05, 1'b1, 2'd1);
    check(4, 7'h05, 1'b1);
    // R10: several idle cycles keep glyph target and address
    repeat (3) @(negedge clk);
    check(10, 7'h05, 1'b1);
    // R1: reset in mid-run clears both outputs
    apply(3'd1, 7'h66, 1'b0, 2'd1);
    rst_n = 0;
    @(posedge clk);
    @(negedge clk);
    check(1, 7'h00, 1'b0);
    rst_n = 1;
    @(negedge clk);
    check(1, 7'h00, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule